// File: doc/BRIEF.md
# Single-Channel Byte-Copy DMA Engine

This block copies a run of bytes from one memory region to another without the processor moving the data. Software first loads three values through a small write-only configuration port: the first source byte address, the first destination byte address and the number of bytes. It then writes a start bit. The engine asks the system arbiter for the shared memory bus and waits for the grant. It keeps the bus from the first access to the last, so the processor cannot reach memory during the copy.

Each byte is paced by the peripheral. The engine moves one byte only in a cycle where the device raises its request while the bus is granted. In that cycle it drives the acknowledge, reads the source address and writes the same byte to the destination address. The memory read port answers in the same cycle and the write is taken at the clock edge. Both addresses step up by one and the remaining count steps down by one. When the count runs out, the engine returns the bus and raises an interrupt. The interrupt stays high until software writes the clear bit.

Top module: `dmac_top`

## Requirements
- R1: After reset, busy, irq, bus_req, dev_ack, mem_re and mem_we are all 0.
- R2: A start write (cfg_addr 3, bit 0 set) with a nonzero count makes busy and bus_req 1 from the next cycle. No memory access happens while bus_gnt is 0.
- R3: dev_ack is 1 only in cycles where dev_req, bus_gnt and bus_req are all 1. mem_re and mem_we are 1 exactly in those cycles.
- R4: The k-th byte moved (k from 0) reads address src+k and writes address dst+k. mem_wdata equals mem_rdata.
- R5: A transfer of N bytes produces exactly N acknowledge cycles.
- R6: In the cycle after the last byte, busy and bus_req are 0 and irq is 1.
- R7: A start write while the count register holds 0 sets irq in the next cycle. It asserts neither busy nor bus_req.
- R8: irq stays 1 until a write to cfg_addr 3 with bit 1 set. It is 0 from the cycle after that write.
- R9: Writes to the source (cfg_addr 0), destination (cfg_addr 1) and count (cfg_addr 2) registers, and start writes, have no effect while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | CFG_W | Write data; on control, bit 0 starts and bit 1 clears irq |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, sticky |
| bus_req | output | 1 | Request for the shared memory bus |
| bus_gnt | input | 1 | Bus granted by the arbiter |
| dev_req | input | 1 | Peripheral asks for one byte |
| dev_ack | output | 1 | Byte moved this cycle |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The checker relies on the arbiter keeping bus_gnt high for as long as bus_req stays high once it has granted. It also relies on the memory returning read data in the same cycle. The bench arbiter grants after a programmable delay and withdraws the grant only after the request falls, so the stimulus never breaks that rule. dev_req is left unconstrained. The bench drives it always high, alternating, or pseudo-random, so acknowledges land in both back-to-back and scattered cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_MOVE = 2'd2
  } dmac_state_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam int CTL_GO_BIT  = 0;
  localparam int CTL_CLR_BIT = 1;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_src,
  input  logic             wr_dst,
  input  logic             wr_cnt,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock,
  input  logic             step,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic             cnt_zero,
  output logic             cnt_last
);
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          src_en, dst_en, cnt_en;

  always_comb begin
    src_en = (wr_src && !lock) || step;
    dst_en = (wr_dst && !lock) || step;
    cnt_en = (wr_cnt && !lock) || step;
    src_d  = step ? src_q + AW'(1) : wdata[AW-1:0];
    dst_d  = step ? dst_q + AW'(1) : wdata[AW-1:0];
    cnt_d  = step ? cnt_q - CW'(1) : wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (dst_en) dst_q <= dst_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign src      = src_q;
  assign dst      = dst_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CW'(1));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic clr,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic bus_gnt,
  input  logic dev_req,
  output logic busy,
  output logic bus_req,
  output logic step,
  output logic irq
);
  dmac_state_e state_q, state_d;
  logic        irq_q, irq_d, irq_set;

  always_comb begin
    state_d = state_q;
    irq_set = 1'b0;
    bus_req = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) irq_set = 1'b1;
          else          state_d = ST_ARB;
        end
      end
      ST_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        bus_req = 1'b1;
        step    = dev_req && bus_gnt;
        if (step && cnt_last) begin
          state_d = ST_IDLE;
          irq_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (irq_set)  irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign irq  = irq_q;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             busy,
  output logic             irq,
  output logic             bus_req,
  input  logic             bus_gnt,
  input  logic             dev_req,
  output logic             dev_ack,
  output logic             mem_re,
  output logic [AW-1:0]    mem_raddr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [DW-1:0]    mem_wdata
);
  logic wr_src, wr_dst, wr_cnt, go, clr;
  logic cnt_zero, cnt_last, step;

  always_comb begin
    wr_src = cfg_we && (cfg_addr == SEL_SRC);
    wr_dst = cfg_we && (cfg_addr == SEL_DST);
    wr_cnt = cfg_we && (cfg_addr == SEL_CNT);
    go     = cfg_we && (cfg_addr == SEL_CTL) && cfg_wdata[CTL_GO_BIT];
    clr    = cfg_we && (cfg_addr == SEL_CTL) && cfg_wdata[CTL_CLR_BIT];
  end

  dmac_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_src   (wr_src),
    .wr_dst   (wr_dst),
    .wr_cnt   (wr_cnt),
    .wdata    (cfg_wdata),
    .lock     (busy),
    .step     (step),
    .src      (mem_raddr),
    .dst      (mem_waddr),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  dmac_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .clr      (clr),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .bus_gnt  (bus_gnt),
    .dev_req  (dev_req),
    .busy     (busy),
    .bus_req  (bus_req),
    .step     (step),
    .irq      (irq)
  );

  assign dev_ack   = step;
  assign mem_re    = step;
  assign mem_we    = step;
  assign mem_wdata = mem_rdata;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int AW    = 16,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             busy,
  input logic             irq,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             dev_req,
  input logic             dev_ack,
  input logic             mem_re,
  input logic             mem_we,
  input logic [AW-1:0]    mem_raddr,
  input logic [AW-1:0]    mem_waddr
);
  logic          seen;
  logic [AW-1:0] last_r, last_w;
  logic          clr_wr;

  assign clr_wr = cfg_we && (cfg_addr == 2'd3) && cfg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      last_r <= '0;
      last_w <= '0;
    end else begin
      if (!busy) seen <= 1'b0;
      else if (dev_ack) seen <= 1'b1;
      if (dev_ack) begin
        last_r <= mem_raddr;
        last_w <= mem_waddr;
      end
    end
  end

  a_r2_busy_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_req);
  a_r3_ack_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (dev_req && bus_gnt && bus_req));
  a_r3_mem_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> dev_ack);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && seen) |-> ((mem_raddr == last_r + AW'(1)) && (mem_waddr == last_w + AW'(1))));
  a_r6_irq_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);
  a_env_gnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (bus_gnt || !bus_req));
endmodule

bind dmac_top dmac_chk #(.AW(AW), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .busy      (busy),
  .irq       (irq),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .dev_req   (dev_req),
  .dev_ack   (dev_ack),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_raddr (mem_raddr),
  .mem_waddr (mem_waddr)
);

// File: tb/tb_dmac_top.sv
`timescale 1ns/1ps
module tb_dmac_top;
  localparam int AW = 16, CW = 16, DW = 8, CFG_W = 16;

  logic             clk, rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_addr;
  logic [CFG_W-1:0] cfg_wdata;
  logic             busy, irq, bus_req, bus_gnt, dev_req, dev_ack;
  logic             mem_re, mem_we;
  logic [AW-1:0]    mem_raddr, mem_waddr;
  logic [DW-1:0]    mem_rdata, mem_wdata;

  dmac_top #(.AW(AW), .CW(CW), .DW(DW), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .irq(irq), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .dev_req(dev_req), .dev_ack(dev_ack),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [AW-1:0] ra;
    logic [AW-1:0] wa;
    logic [DW-1:0] d;
  } exp_t;
  exp_t sbq[$];

  int errors = 0;
  int checks = 0;
  int acks   = 0;
  bit done_flag = 0;

  // memory model: 256 bytes, same-cycle read, write at the edge
  logic [DW-1:0] mem [256];
  function automatic logic [DW-1:0] init_byte(int a);
    return DW'(a * 7 + 3);
  endfunction
  assign mem_rdata = mem[mem_raddr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_waddr[7:0]] <= mem_wdata;

  // arbiter model with programmable grant latency
  int gnt_delay = 0;
  int gnt_cnt   = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      gnt_cnt <= 0;
    end else if (!bus_req) begin
      bus_gnt <= 1'b0;
      gnt_cnt <= 0;
    end else if (!bus_gnt) begin
      if (gnt_cnt >= gnt_delay) bus_gnt <= 1'b1;
      else gnt_cnt <= gnt_cnt + 1;
    end
  end

  // device request pattern: 0 always, 1 alternate, 2 pseudo-random
  int       req_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  int       phase = 0;
  initial begin
    dev_req = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      phase++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (req_mode)
        0: dev_req = 1'b1;
        1: dev_req = phase[0];
        default: dev_req = lfsr[0];
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every acknowledge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if ((mem_re || mem_we) && !bus_gnt)
        check(1'b0, "R2", "memory access without grant", 1, 0);
      if (mem_re != dev_ack || mem_we != dev_ack)
        check(1'b0, "R3", "mem enables differ from ack", {mem_re, mem_we}, {dev_ack, dev_ack});
      if (dev_ack) begin
        acks++;
        check(dev_req && bus_gnt && bus_req, "R3", "ack without req/gnt",
              {dev_req, bus_gnt, bus_req}, 3'b111);
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "unexpected extra byte", mem_waddr, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(mem_raddr == e.ra, "R4", "read address", mem_raddr, e.ra);
          check(mem_waddr == e.wa, "R4", "write address", mem_waddr, e.wa);
          check(mem_wdata == e.d,  "R4", "byte value", mem_wdata, e.d);
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [CFG_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  // driver: programs a transfer and pushes what the monitor must see
  task automatic start_xfer(input int src, input int dst, input int n);
    cfg_write(2'd0, CFG_W'(src));
    cfg_write(2'd1, CFG_W'(dst));
    cfg_write(2'd2, CFG_W'(n));
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.ra = AW'(src + k);
      e.wa = AW'(dst + k);
      e.d  = init_byte(src + k);
      sbq.push_back(e);
    end
    acks = 0;
    cfg_write(2'd3, 16'h0001);
  endtask

  task automatic wait_done(input int n);
    int guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(sbq.size() == 0, "R5", "bytes left in scoreboard", sbq.size(), 0);
    check(acks == n, "R5", "acknowledge count", acks, n);
    check(!busy && !bus_req, "R6", "busy/bus_req after last byte", {busy, bus_req}, 0);
    check(irq == 1'b1, "R6", "irq after last byte", irq, 1);
  endtask

  task automatic clear_irq();
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R8", "irq held before clear", irq, 1);
    cfg_write(2'd3, 16'h0002);
    check(irq == 1'b0, "R8", "irq after clear", irq, 0);
  endtask

  task automatic finish_report();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, irq, bus_req, dev_ack, mem_re, mem_we} == 6'b0, "R1", "outputs in reset",
          {busy, irq, bus_req, dev_ack, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, irq, bus_req, dev_ack, mem_re, mem_we} == 6'b0, "R1", "outputs after reset",
          {busy, irq, bus_req, dev_ack, mem_re, mem_we}, 0);

    // transfer 1: device always ready, immediate grant
    req_mode = 0; gnt_delay = 0;
    start_xfer(16'h10, 16'h80, 5);
    check(busy && bus_req, "R2", "busy/bus_req after start", {busy, bus_req}, 2'b11);
    wait_done(5);
    clear_irq();

    // transfer 2: alternating device, slow grant, writes and start while busy
    req_mode = 1; gnt_delay = 3;
    start_xfer(16'h20, 16'hA0, 9);
    check(busy && bus_req && !mem_re, "R2", "waiting for grant", {busy, bus_req, mem_re}, 3'b110);
    cfg_write(2'd1, 16'h00F0);   // R9 ignored destination write
    cfg_write(2'd0, 16'h0000);   // R9 ignored source write
    cfg_write(2'd2, 16'h0002);   // R9 ignored count write
    cfg_write(2'd3, 16'h0001);   // R9 ignored start
    wait_done(9);
    clear_irq();
    // R9: the count ran out, so a fresh start finishes at once with no bus request
    cfg_write(2'd3, 16'h0001);
    check(irq && !busy && !bus_req, "R9", "count not altered while busy",
          {irq, busy, bus_req}, 3'b100);
    clear_irq();

    // R7 explicit zero-count start
    cfg_write(2'd2, 16'h0000);
    cfg_write(2'd3, 16'h0001);
    check(irq == 1'b1, "R7", "irq on zero count", irq, 1);
    check(!busy && !bus_req, "R7", "no bus activity on zero count", {busy, bus_req}, 0);
    repeat (2) @(negedge clk);
    check(!bus_req && acks == 0 + acks, "R7", "bus stays idle", bus_req, 0);
    clear_irq();

    // transfer 3: pseudo-random device pacing, one-cycle grant latency
    req_mode = 2; gnt_delay = 1;
    start_xfer(16'h40, 16'hC0, 12);
    wait_done(12);
    for (int k = 0; k < 12; k++)
      check(mem[8'hC0 + k] == init_byte(16'h40 + k), "R4", "destination contents",
            mem[8'hC0 + k], init_byte(16'h40 + k));
    clear_irq();

    // single-byte transfer
    req_mode = 0; gnt_delay = 2;
    start_xfer(16'h05, 16'hE0, 1);
    wait_done(1);
    clear_irq();

    finish_report();
  end
endmodule